// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers thirty-two interrupt sources and turns each one into a request on one or more of sixteen output lines. The lines form a grid of four cores by four parent lines. Each source is first conditioned by a per-source trigger mode: level high, level low, rising edge or falling edge. It is then gated by a per-source enable. Finally it is steered by a route byte that holds a one-hot parent field and a one-hot core field. Each core also gets a summary request line.

Software reaches the block through a plain 32-bit register port. The port carries a byte address, a write strobe, four byte enables and write data. Read data is combinational from the address. Sets of enable bits are changed through separate set and clear addresses, so no read-modify-write is needed. A sticky edge request is cleared by writing a one to its bit in the pending word. The sources are assumed to be synchronous to the register clock. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable mask, polarity word, trigger-mode word, all route bytes and all output lines read as zero.
- R2: The route byte of source n sits at byte address n (0x00 to 0x1F). Bits [7:4] select parent lines and bits [3:0] select cores. Each byte lane of a write updates only its own route byte, and a route word reads back packed with source 4k+j in bits [8j+7:8j].
- R3: A write to 0x28 sets the enable bits where the data has ones. Zero bits leave enables unchanged. The mask reads at 0x24.
- R4: A write to 0x2C clears the enable bits where the data has ones. Zero bits leave enables unchanged.
- R5: Polarity sits at 0x30 and trigger mode at 0x34. With mode bit 0, a source is pending while its input equals its polarity bit (1 = high, 0 = low), with no latching.
- R6: With mode bit 1 and polarity 1, a rising input sets a sticky request, visible after the clock edge that samples it. Writing 1 to its bit at 0x40 clears it. If a new edge arrives in the same cycle as the clear, the edge wins.
- R7: With mode bit 1 and polarity 0, a falling input sets the sticky request. A rising input does not set it.
- R8: Address 0x40 reads the pending word: requested AND enabled. Disabling a source hides a latched request without discarding it.
- R9: Output line c*4+p is the OR of all pending enabled sources whose route byte has core bit c and parent bit 4+p set. One source may reach several lines.
- R10: Core summary line c is the OR of the four lines of core c.
- R11: Byte enables mask every write. Bits in lanes with byte enable 0 act as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src | input | 32 | Raw interrupt sources, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address of the access |
| be | input | 4 | Byte enables of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq_lines | output | 16 | Request grid, index core*4+parent |
| core_irq | output | 4 | Per-core OR of its request lines |

## Verification
The bench tests partial byte-lane writes to route words and to the enable set address. A design that ignored the byte enables would corrupt neighbouring route bytes or enable stray sources. It checks that a level source drops as soon as its input returns, while an edge source holds its request after the input goes back. A design with the wrong latching would leave a level request stuck, or lose an edge request. It also disables a source while its edge request is latched and then re-enables it. The request must reappear, which fails if masking clears the latch. A route byte with two core bits and two parent bits checks that fan-out reaches all four grid lines.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] ADR_EN_STAT = 8'h24;
  localparam logic [AW-1:0] ADR_EN_SET  = 8'h28;
  localparam logic [AW-1:0] ADR_EN_CLR  = 8'h2C;
  localparam logic [AW-1:0] ADR_POL     = 8'h30;
  localparam logic [AW-1:0] ADR_MODE    = 8'h34;
  localparam logic [AW-1:0] ADR_PEND    = 8'h40;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NPAR  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [3:0]                 be,
  input  logic [31:0]                wdata,
  input  logic [NSRC-1:0]            pend_stat,
  output logic [31:0]                rdata,
  output logic [NSRC-1:0]            enable,
  output logic [NSRC-1:0]            pol,
  output logic [NSRC-1:0]            mode,
  output logic [NSRC-1:0][NPAR+NCORE-1:0] route,
  output logic [NSRC-1:0]            pend_clr
);
  localparam int RB     = NPAR + NCORE;
  localparam int NWORDS = NSRC / 4;

  logic [31:0]     wmask;
  logic [NSRC-1:0] wbits;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign wmask[8*l +: 8] = {8{be[l]}};
  end
  assign wbits = NSRC'(wdata & wmask);

  // enable mask with separate set and clear ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      pol    <= '0;
      mode   <= '0;
    end else if (wr_en) begin
      if (addr == ADR_EN_SET) enable <= enable | wbits;
      if (addr == ADR_EN_CLR) enable <= enable & ~wbits;
      if (addr == ADR_POL)    pol    <= (pol  & ~NSRC'(wmask)) | wbits;
      if (addr == ADR_MODE)   mode   <= (mode & ~NSRC'(wmask)) | wbits;
    end
  end

  // route bytes, one per source, written by byte lane
  for (genvar s = 0; s < NSRC; s++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route[s] <= '0;
      else if (wr_en && addr[AW-1:2] == (AW-2)'(s / 4) && be[s % 4])
        route[s] <= wdata[8*(s % 4) +: RB];
    end
  end

  assign pend_clr = (wr_en && addr == ADR_PEND) ? wbits : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_EN_STAT: rdata = 32'(enable);
      ADR_POL:     rdata = 32'(pol);
      ADR_MODE:    rdata = 32'(mode);
      ADR_PEND:    rdata = 32'(pend_stat);
      default: begin
        if (addr[1:0] == 2'b00 && int'(addr[AW-1:2]) < NWORDS) begin
          for (int k = 0; k < 4; k++)
            rdata[8*k +: RB] = route[int'(addr[AW-1:2]) * 4 + k];
        end
      end
    endcase
  end

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_EN_SET) |=> ((enable & $past(wbits)) == $past(wbits)));
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_EN_CLR) |=> ((enable & $past(wbits)) == '0));
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADR_EN_SET || addr == ADR_EN_CLR)) |=> $stable(enable));
endmodule

// File: rtl/irq_router_cond.sv
module irq_router_cond #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] mode,
  input  logic [NSRC-1:0] pend_clr,
  output logic [NSRC-1:0] pend_raw
);
  logic [NSRC-1:0] prev_src;
  logic [NSRC-1:0] sticky;
  logic [NSRC-1:0] edge_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign edge_hit[i] = pol[i] ? (src[i] & ~prev_src[i]) : (~src[i] & prev_src[i]);
    assign pend_raw[i] = mode[i] ? sticky[i] : (src[i] == pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_src[i] <= 1'b0;
        sticky[i]   <= 1'b0;
      end else begin
        prev_src[i] <= src[i];
        // an edge in the same cycle as a clear wins; level mode keeps no latch
        sticky[i]   <= mode[i] & (edge_hit[i] | (sticky[i] & ~pend_clr[i]));
      end
    end
  end

  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr == '0) |=> ((sticky & $past(sticky & mode)) == $past(sticky & mode)));
  a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & $past(edge_hit & mode)) == $past(edge_hit & mode)));
endmodule

// File: rtl/irq_router_xbar.sv
module irq_router_xbar #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NPAR  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NSRC-1:0]                 pend,
  input  logic [NSRC-1:0][NPAR+NCORE-1:0] route,
  output logic [NCORE*NPAR-1:0]           lines,
  output logic [NCORE-1:0]                core_irq
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar p = 0; p < NPAR; p++) begin : g_par
      logic [NSRC-1:0] hit;
      for (genvar s = 0; s < NSRC; s++) begin : g_s
        assign hit[s] = pend[s] & route[s][c] & route[s][NCORE+p];
      end
      assign lines[c*NPAR+p] = |hit;
    end
    assign core_irq[c] = |lines[c*NPAR +: NPAR];
  end

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (lines == '0 && core_irq == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NPAR  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NCORE*NPAR-1:0]  irq_lines,
  output logic [NCORE-1:0]       core_irq
);
  localparam int RB = NPAR + NCORE;

  logic [NSRC-1:0]         enable, pol, mode, pend_clr, pend_raw, pend_stat;
  logic [NSRC-1:0][RB-1:0] route;

  irq_router_regs #(.NSRC(NSRC), .NCORE(NCORE), .NPAR(NPAR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .pend_stat(pend_stat), .rdata(rdata), .enable(enable),
    .pol(pol), .mode(mode), .route(route), .pend_clr(pend_clr));

  irq_router_cond #(.NSRC(NSRC)) u_cond (
    .clk(clk), .rst_n(rst_n), .src(src), .pol(pol), .mode(mode),
    .pend_clr(pend_clr), .pend_raw(pend_raw));

  assign pend_stat = pend_raw & enable;

  irq_router_xbar #(.NSRC(NSRC), .NCORE(NCORE), .NPAR(NPAR)) u_xbar (
    .clk(clk), .rst_n(rst_n), .pend(pend_stat), .route(route),
    .lines(irq_lines), .core_irq(core_irq));
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq_lines;
  logic [3:0]  core_irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 lines, 2 core summary
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
    .be(be), .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines),
    .core_irq(core_irq));

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? 32'(irq_lines) : 32'(core_irq);
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d; be = b;
    @(posedge clk); #1;
    wr_en = 1'b0; be = '0;
  endtask

  task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(posedge clk); #1;
    src = v;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(0, 8'h24, 32'h0, "R1 enable");
    chk(0, 8'h30, 32'h0, "R1 pol");
    chk(0, 8'h34, 32'h0, "R1 mode");
    chk(0, 8'h00, 32'h0, "R1 route");
    chk(1, 8'h00, 32'h0, "R1 lines");
    chk(0, 8'h40, 32'h0, "R8 pending masked at reset");
    // R2 route bytes
    wr(8'h00, 32'h8844_2211, 4'hF);
    chk(0, 8'h00, 32'h8844_2211, "R2 route word");
    wr(8'h04, 32'hAABB_CCDD, 4'b0010);
    chk(0, 8'h04, 32'h0000_CC00, "R2 R11 lane write");
    // R3 R4 R11 enables
    wr(8'h28, 32'h0000_000F, 4'hF);
    chk(0, 8'h24, 32'h0000_000F, "R3 set");
    wr(8'h28, 32'h0000_0020, 4'hF);
    chk(0, 8'h24, 32'h0000_002F, "R3 zeros keep");
    wr(8'h2C, 32'h0000_0001, 4'hF);
    chk(0, 8'h24, 32'h0000_002E, "R4 clear");
    wr(8'h28, 32'hFFFF_FF00, 4'b0001);
    chk(0, 8'h24, 32'h0000_002E, "R11 masked lanes");
    wr(8'h28, 32'h0000_0001, 4'hF);
    // R5 level low default, all inputs low
    chk(0, 8'h40, 32'h0000_002F, "R5 level low pending");
    chk(1, 8'h00, 32'h0000_CC21, "R9 grid fanout");
    chk(2, 8'h00, 32'h0000_000F, "R10 core summary");
    // R5 level high
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    chk(0, 8'h40, 32'h0, "R5 level high idle");
    set_src(32'h2);
    chk(0, 8'h40, 32'h2, "R5 level high active");
    chk(1, 8'h00, 32'h0000_0020, "R9 single line");
    chk(2, 8'h00, 32'h2, "R10 single core");
    set_src(32'h0);
    chk(0, 8'h40, 32'h0, "R5 no latch");
    // R6 rising edge
    wr(8'h34, 32'h1, 4'hF);
    set_src(32'h1);
    chk(0, 8'h40, 32'h1, "R6 rise latched");
    set_src(32'h0);
    chk(0, 8'h40, 32'h1, "R6 sticky");
    chk(1, 8'h00, 32'h1, "R9 edge line");
    wr(8'h40, 32'h1, 4'hF);
    chk(0, 8'h40, 32'h0, "R6 w1c");
    // R7 falling edge
    wr(8'h30, 32'hFFFF_FFFE, 4'hF);
    set_src(32'h1);
    chk(0, 8'h40, 32'h0, "R7 rise ignored");
    set_src(32'h0);
    chk(0, 8'h40, 32'h1, "R7 fall latched");
    // R8 masking keeps latch
    wr(8'h2C, 32'h1, 4'hF);
    chk(0, 8'h40, 32'h0, "R8 hidden");
    chk(1, 8'h00, 32'h0, "R8 lines hidden");
    wr(8'h28, 32'h1, 4'hF);
    chk(0, 8'h40, 32'h1, "R8 latch kept");
    wr(8'h40, 32'h1, 4'hF);
    chk(0, 8'h40, 32'h0, "R6 final clear");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule